// File: doc/BRIEF.md
# Seeded Pseudorandom Pattern Sequencer for Hybrid Self-Test

This block runs the stimulus side of a hybrid self-test. A seed store outside the block holds a short list of deterministic words. Each word pairs a starting state for a linear feedback shift register with the number of patterns to produce from that state. The words are chosen to reach faults that random patterns rarely hit. After a start pulse, the sequencer reads the words one by one. It loads each seed into the register and streams that many patterns, one per clock. It then moves to the next word.

A pattern counter tracks progress inside a group. An address counter walks the seed store. A small state machine (idle, read, load, generate, done) ties the two counters together. The seed is itself the first pattern of its group. A count of zero skips the word. After the last word, the block raises a done flag, and the flag stays high until the next start.

Top module: `hybrid_bist_seq`

## Requirements
- R1: After reset, `done`, `pat_valid` and `seed_rd` are all low, and they stay low until `start` is seen.
- R2: A `start` sampled while idle or done gives `seed_rd` high with `seed_addr` = 0 in the next cycle, for exactly one cycle.
- R3: The seed word is sampled one cycle after its read strobe. Bits [PAT_W-1:0] hold the starting state and bits [PAT_W+CNT_W-1:PAT_W] hold the pattern count.
- R4: The first valid pattern of a group equals the seed. It appears two cycles after the read strobe.
- R5: Each further pattern of a group follows the previous one on the next clock, with no gap. The next pattern is the previous one shifted right by one bit, then XORed with TAPS (default 16'hB400) when the bit shifted out was 1.
- R6: A word with count N gives exactly N valid patterns. The read of address k+1 follows in the cycle after the last of them.
- R7: A word with count zero gives no pattern. The next read comes two cycles after the previous read.
- R8: After the last word is finished, `done` rises in the next cycle and holds until `start`. A `start` while done clears `done` and restarts from address 0.
- R9: A `start` pulse while a run is in progress is ignored, and the output sequence is unchanged.
- R10: In any cycle, at most one of `seed_rd`, `pat_valid` and `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled when idle or done) |
| done | output | 1 | Run complete, held until next start |
| seed_addr | output | ADDR_W | Seed store address |
| seed_rd | output | 1 | Seed store read strobe |
| seed_data | input | CNT_W+PAT_W | Seed word: count above, starting state below |
| pat_out | output | PAT_W | Current pattern |
| pat_valid | output | 1 | Pattern on `pat_out` is valid |

## Verification
Three situations are hard to reach from the ports. The first is a zero-count word sitting between groups, where the next read strobe comes two cycles after the previous one with no pattern between them. The second is a zero-count word as the final entry, so the run ends straight from the load step. The third is a start pulse in the middle of a group. The stimulus reaches these cases by loading a different seed store for each run. It also raises `start` partway through one group and checks that the stream does not change. A long group of 900 patterns and one of 275 make sure the counter handles counts above a single byte.

// File: rtl/hbist_pkg.sv
package hbist_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_LOAD,
      ST_GEN,
      ST_DONE
   } seq_state_e;
endpackage

// File: rtl/hbist_lfsr.sv
module hbist_lfsr #(
   parameter int          W         = 16,
   parameter logic [W-1:0] TAPS     = 16'hB400,
   parameter bit          FIBONACCI = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] state
);
   logic [W-1:0] nxt;

   generate
      if (FIBONACCI) begin : g_fib
         always_comb nxt = {state[W-2:0], ^(state & TAPS)};
      end else begin : g_gal
         always_comb nxt = (state >> 1) ^ (state[0] ? TAPS : '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= '0;
      else if (load) state <= load_val;
      else if (step) state <= nxt;
   end

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> state == $past(load_val)); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !step |=> $stable(state)); // R5
endmodule

// File: rtl/hbist_pat_cnt.sv
module hbist_pat_cnt #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     remain <= '0;
      else if (load)  remain <= load_val;
      else if (dec)   remain <= remain - 1'b1;
   end

   assign last = (remain == CNT_W'(1));

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> remain != '0); // R6
endmodule

// File: rtl/hbist_addr_cnt.sv
module hbist_addr_cnt #(
   parameter int NUM_SEEDS = 4,
   parameter int ADDR_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr,
   output logic              at_end
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_SEEDS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr <= '0;
      else if (clr)   addr <= '0;
      else if (inc)   addr <= addr + 1'b1;
   end

   assign at_end = (addr == LAST);

   AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      addr <= LAST); // R6
   AST_NO_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> !at_end); // R8
endmodule

// File: rtl/hybrid_bist_seq.sv
module hybrid_bist_seq
   import hbist_pkg::*;
#(
   parameter int             PAT_W     = 16,
   parameter int             CNT_W     = 12,
   parameter int             NUM_SEEDS = 4,
   parameter logic [PAT_W-1:0] TAPS    = 16'hB400,
   parameter bit             FIBONACCI = 1'b0,
   localparam int            ADDR_W    = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1,
   localparam int            WORD_W    = CNT_W + PAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic [ADDR_W-1:0] seed_addr,
   output logic              seed_rd,
   input  logic [WORD_W-1:0] seed_data,
   output logic [PAT_W-1:0]  pat_out,
   output logic              pat_valid
);
   initial begin
      assert (PAT_W >= 2) else $error("PAT_W must be at least 2");
      assert (CNT_W >= 1) else $error("CNT_W must be at least 1");
      assert (NUM_SEEDS >= 1) else $error("NUM_SEEDS must be at least 1");
      assert (TAPS != '0) else $error("TAPS must not be zero");
   end

   seq_state_e state_q, state_d;
   logic addr_clr, addr_inc, addr_end;
   logic lfsr_load, lfsr_step;
   logic cnt_load, cnt_dec, cnt_last;

   wire [PAT_W-1:0] word_seed  = seed_data[PAT_W-1:0];
   wire [CNT_W-1:0] word_count = seed_data[WORD_W-1:PAT_W];

   always_comb begin
      state_d   = state_q;
      addr_clr  = 1'b0;
      addr_inc  = 1'b0;
      lfsr_load = 1'b0;
      lfsr_step = 1'b0;
      cnt_load  = 1'b0;
      cnt_dec   = 1'b0;
      unique case (state_q)
         ST_IDLE, ST_DONE: begin
            if (start) begin
               state_d  = ST_READ;
               addr_clr = 1'b1;
            end
         end
         ST_READ: state_d = ST_LOAD;
         ST_LOAD: begin
            lfsr_load = 1'b1;
            cnt_load  = 1'b1;
            if (word_count != '0) state_d = ST_GEN;
            else if (addr_end)    state_d = ST_DONE;
            else begin
               addr_inc = 1'b1;
               state_d  = ST_READ;
            end
         end
         ST_GEN: begin
            lfsr_step = 1'b1;
            cnt_dec   = 1'b1;
            if (cnt_last) begin
               if (addr_end) state_d = ST_DONE;
               else begin
                  addr_inc = 1'b1;
                  state_d  = ST_READ;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   hbist_addr_cnt #(.NUM_SEEDS(NUM_SEEDS), .ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
      .addr(seed_addr), .at_end(addr_end));

   hbist_pat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(word_count),
      .dec(cnt_dec), .last(cnt_last));

   hbist_lfsr #(.W(PAT_W), .TAPS(TAPS), .FIBONACCI(FIBONACCI)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .load(lfsr_load), .load_val(word_seed),
      .step(lfsr_step), .state(pat_out));

   assign seed_rd   = (state_q == ST_READ);
   assign pat_valid = (state_q == ST_GEN);
   assign done      = (state_q == ST_DONE);

   AST_START_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start && (done || state_q == ST_IDLE) |=> seed_rd && seed_addr == '0); // R2
   AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_LOAD |-> $past(seed_rd)); // R3
   AST_FIRST_IS_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      pat_valid && $past(state_q == ST_LOAD) |-> pat_out == $past(word_seed)); // R4
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done); // R8
   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({seed_rd, pat_valid, done})); // R10
endmodule

// File: tb/tb_hybrid_bist_seq.sv
module tb_hybrid_bist_seq;
   localparam int PAT_W = 16;
   localparam int CNT_W = 12;
   localparam int NS    = 4;
   localparam int AW    = 2;
   localparam logic [PAT_W-1:0] POLY = 16'hB400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic done, seed_rd, pat_valid;
   logic [AW-1:0] seed_addr;
   logic [CNT_W+PAT_W-1:0] seed_data;
   logic [PAT_W-1:0] pat_out;
   logic [CNT_W+PAT_W-1:0] mem [NS];

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;

   typedef struct {
      bit rd; int addr; bit valid; logic [PAT_W-1:0] pat; bit dn; string tag;
   } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;

   always @(posedge clk) if (seed_rd) seed_data <= mem[seed_addr];

   hybrid_bist_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done),
      .seed_addr(seed_addr), .seed_rd(seed_rd), .seed_data(seed_data),
      .pat_out(pat_out), .pat_valid(pat_valid));

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         mismatched++;
         $display("FAIL watchdog: actual cycles %0d expected completion", cycles);
         summary();
      end
   end

   function automatic logic [PAT_W-1:0] nxt(logic [PAT_W-1:0] s);
      logic [PAT_W-1:0] r = s >> 1;
      if (s[0]) r = r ^ POLY;
      return r;
   endfunction

   task automatic push(bit rd, int a, bit v, logic [PAT_W-1:0] p, bit dn, string tag);
      exp_t e;
      e.rd = rd; e.addr = a; e.valid = v; e.pat = p; e.dn = dn; e.tag = tag;
      q.push_back(e);
   endtask

   // reference stream: R3 word layout, R4 seed first, R5 stepping, R6/R7 counts, R8 done
   task automatic build();
      bit prev_zero = 0;
      for (int k = 0; k < NS; k++) begin
         logic [PAT_W-1:0] s = mem[k][PAT_W-1:0];
         int n = int'(mem[k][CNT_W+PAT_W-1:PAT_W]);
         push(1, k, 0, '0, 0, k == 0 ? "R2" : (prev_zero ? "R7" : "R6"));
         push(0, 0, 0, '0, 0, "R3");
         for (int i = 0; i < n; i++) begin
            push(0, 0, 1, s, 0, i == 0 ? "R4" : "R5");
            s = nxt(s);
         end
         prev_zero = (n == 0);
      end
      push(0, 0, 0, '0, 1, "R8");
   endtask

   task automatic check_excl();
      compared++;
      if (int'(seed_rd) + int'(pat_valid) + int'(done) > 1) begin
         mismatched++;
         $display("FAIL R10: actual rd/valid/done %b%b%b expected at most one high",
                  seed_rd, pat_valid, done);
      end
   endtask

   task automatic run(int busy_at);
      int idx = 0;
      build();
      @(negedge clk) start = 1'b1;
      while (q.size() > 0) begin
         exp_t e;
         @(negedge clk);
         start = (idx == busy_at);
         e = q.pop_front();
         compared++;
         if (seed_rd !== e.rd || (e.rd && int'(seed_addr) != e.addr) ||
             pat_valid !== e.valid || (e.valid && pat_out !== e.pat) || done !== e.dn) begin
            mismatched++;
            $display("FAIL %s%s: actual rd=%b a=%0d v=%b p=%h d=%b expected rd=%b a=%0d v=%b p=%h d=%b",
                     e.tag, busy_at >= 0 ? " R9" : "", seed_rd, seed_addr, pat_valid, pat_out, done,
                     e.rd, e.addr, e.valid, e.pat, e.dn);
         end
         check_excl();
         idx++;
      end
      start = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         compared++;
         if (done !== 1'b1 || pat_valid !== 1'b0 || seed_rd !== 1'b0) begin
            mismatched++;
            $display("FAIL R8: actual done=%b v=%b rd=%b expected 1 0 0", done, pat_valid, seed_rd);
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         compared++;
         if (done !== 1'b0 || pat_valid !== 1'b0 || seed_rd !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: actual done=%b v=%b rd=%b expected 0 0 0", done, pat_valid, seed_rd);
         end
      end
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         compared++;
         if (done !== 1'b0 || pat_valid !== 1'b0 || seed_rd !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: idle actual done=%b v=%b rd=%b expected 0 0 0", done, pat_valid, seed_rd);
         end
      end
      // run 1: short groups, a zero-count word between groups (R7)
      mem[0] = {12'd5, 16'hACE1};
      mem[1] = {12'd0, 16'h1234};
      mem[2] = {12'd3, 16'h8001};
      mem[3] = {12'd1, 16'hFFFF};
      run(-1);
      // run 2: restart from done (R8), long groups, zero count last, busy start (R9)
      mem[0] = {12'd275, 16'h0F0F};
      mem[1] = {12'd2,   16'h5A5A};
      mem[2] = {12'd900, 16'h7777};
      mem[3] = {12'd0,   16'hC3C3};
      run(40);
      // run 3: every word skipped
      mem[0] = {12'd0, 16'h1111};
      mem[1] = {12'd0, 16'h2222};
      mem[2] = {12'd0, 16'h3333};
      mem[3] = {12'd0, 16'h4444};
      run(-1);
      summary();
   end
endmodule